// File: doc/BRIEF.md
# Output-Stationary Systolic Matrix Multiplier

This block multiplies two square N×N matrices of unsigned operands, C = A·B, on a two-dimensional grid of multiply-accumulate cells. Each cell owns exactly one result element and keeps its running sum in place. Operands of A enter at the west edge and travel east one cell per cycle. Operands of B enter at the north edge and travel south the same way. Small delay lines at both edges stagger the lanes so that a(i,k) and b(k,j) arrive together in cell (i,j) on cycle i+j+k. Once the pipeline fills, every cell does useful work on every cycle.

A host first writes the two matrices element by element into two operand stores. It then pulses `start`. The controller streams one column of A and one row of B per cycle for N cycles and feeds zeros after that. It raises `done` once the far corner cell has taken its last term. The results are then read one element per cycle through a row/column address port. The operand stores keep their contents, so the same pair can be multiplied again without reloading.

Top module: `smm_top`

## Requirements
- R1: After reset `done` is 0 and a read of any result address returns 0.
- R2: After a run, the result at (i,j) equals the full unsigned sum over k of a(i,k)·b(k,j), for any operand values.
- R3: An accepted start clears every accumulator, so no result carries terms from an earlier run.
- R4: `done` rises exactly 3N-2 clock edges after the edge that accepts `start` (22 for N=8). It stays high until the next accepted start and drops on that edge.
- R5: A `start` pulse seen while a run is in progress is ignored. It changes neither the timing of `done` nor the results.
- R6: `rd_data` shows the result at (`rd_row`,`rd_col`) one clock after the address is presented.
- R7: A write with `a_we` stores `a_data` as a(row,col), and a write with `b_we` stores `b_data` as b(row,col). Stored operands persist across runs, and a later write to one element replaces only that element.
- R8: With every operand at 255, each result is N·255·255 (520200 for N=8) without wrap in the AW-bit result.
- R9: With A the identity matrix, the results equal B element for element.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| a_we | input | 1 | Write strobe for the A store |
| a_row | input | IW | Row index of the A element written |
| a_col | input | IW | Column index of the A element written |
| a_data | input | DW | Unsigned A element value |
| b_we | input | 1 | Write strobe for the B store |
| b_row | input | IW | Row index of the B element written |
| b_col | input | IW | Column index of the B element written |
| b_data | input | DW | Unsigned B element value |
| start | input | 1 | One-cycle request to multiply the stored pair |
| done | output | 1 | Results complete and stable |
| rd_row | input | IW | Row index of the result to read |
| rd_col | input | IW | Column index of the result to read |
| rd_data | output | AW | Result element, registered |

## Verification
The bench hits the skew alignment with random matrices. If a lane were delayed by one cycle too many or too few, operands of different k would meet and off-diagonal results would be wrong. All-255 operands would show a narrowed accumulator or a truncated product as wrapped values. The identity case and a rerun after a one-element rewrite would expose an accumulator not cleared on start, which would show doubled or stale sums. Extra start pulses in mid-run and a cycle-exact model of `done` catch a controller that restarts or ends one cycle early. Ending early would miss the last term of the corner cell.

// File: rtl/smm_pkg.sv
package smm_pkg;
  typedef enum logic {ST_IDLE = 1'b0, ST_RUN = 1'b1} smm_state_e;
endpackage

// File: rtl/smm_opbuf.sv
// Operand store: N lanes by N steps. A read returns one value per lane
// for a chosen step, or zeros when the read is not valid.
module smm_opbuf #(
  parameter int N  = 8,
  parameter int DW = 8,
  localparam int IW = $clog2(N)
) (
  input  logic          clk,
  input  logic          wr_en,
  input  logic [IW-1:0] wr_lane,
  input  logic [IW-1:0] wr_step,
  input  logic [DW-1:0] wr_data,
  input  logic          rd_vld,
  input  logic [IW-1:0] rd_step,
  output logic [DW-1:0] lane_out [N]
);
  logic [DW-1:0] mem [N][N];

  // storage array, no reset: contents are defined by host writes
  always_ff @(posedge clk) begin
    if (wr_en) begin
      mem[wr_lane][wr_step] <= wr_data;
    end
  end

  always_comb begin
    for (int l = 0; l < N; l++) begin
      lane_out[l] = rd_vld ? mem[l][rd_step] : '0;
    end
  end
endmodule

// File: rtl/smm_skew.sv
// Edge skew: lane l is delayed by l cycles before it enters the grid.
module smm_skew #(
  parameter int N  = 8,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [DW-1:0] din  [N],
  output logic [DW-1:0] dout [N]
);
  for (genvar l = 0; l < N; l++) begin : g_lane
    if (l == 0) begin : g_direct
      assign dout[0] = din[0];
    end else begin : g_delay
      logic [DW-1:0] sh    [l];
      logic [DW-1:0] sh_nx [l];

      always_comb begin
        sh_nx[0] = din[l];
        for (int m = 1; m < l; m++) begin
          sh_nx[m] = sh[m-1];
        end
      end

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          for (int m = 0; m < l; m++) sh[m] <= '0;
        end else begin
          for (int m = 0; m < l; m++) sh[m] <= sh_nx[m];
        end
      end

      assign dout[l] = sh[l-1];

      if (l == 1) begin : g_chk
        // R2: a one-deep lane presents its input one edge later
        p_lane_one_delay_r2: assert property (@(posedge clk) disable iff (!rst_n)
          dout[1] == $past(din[1]));
      end
    end
  end
endmodule

// File: rtl/smm_cell.sv
// One grid cell: result held in place, operands forwarded east and south.
module smm_cell #(
  parameter int DW = 8,
  parameter int AW = 19
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en,
  input  logic          clr,
  input  logic [DW-1:0] a_in,
  input  logic [DW-1:0] b_in,
  output logic [DW-1:0] a_out,
  output logic [DW-1:0] b_out,
  output logic [AW-1:0] acc
);
  localparam int PW = 2 * DW;

  logic [PW-1:0] prod;
  logic [AW-1:0] prod_ext;
  logic [AW-1:0] acc_nx;
  logic [DW-1:0] a_q, b_q;

  always_comb begin
    prod     = a_in * b_in;
    prod_ext = AW'(prod);
    if (clr) begin
      acc_nx = '0;
    end else if (en) begin
      acc_nx = acc + prod_ext;
    end else begin
      acc_nx = acc;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc <= '0;
      a_q <= '0;
      b_q <= '0;
    end else begin
      acc <= acc_nx;
      a_q <= a_in;
      b_q <= b_in;
    end
  end

  assign a_out = a_q;
  assign b_out = b_q;

  // R3: a cleared cell starts the run from zero
  p_clear_to_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (acc == '0));
  // R8: accumulation never wraps
  p_no_wrap_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (en && !clr) |=> (acc >= $past(acc)));
endmodule

// File: rtl/smm_ctrl.sv
// Run sequencer: counts 0 .. 3N-3 while running, streams N feed steps.
module smm_ctrl
  import smm_pkg::*;
#(
  parameter int N = 8,
  localparam int IW = $clog2(N),
  localparam int CW = $clog2(3 * N)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  output logic          fire,
  output logic          run,
  output logic          feed_vld,
  output logic [IW-1:0] step,
  output logic          done
);
  localparam logic [CW-1:0] LAST = CW'(3 * N - 3);
  localparam logic [CW-1:0] NLIM = CW'(N);

  smm_state_e    state, state_nx;
  logic [CW-1:0] cnt, cnt_nx;
  logic          done_nx;
  logic          last;

  always_comb begin
    fire     = start && (state == ST_IDLE);
    last     = (state == ST_RUN) && (cnt == LAST);
    state_nx = state;
    cnt_nx   = cnt;
    done_nx  = done;
    if (fire) begin
      state_nx = ST_RUN;
      cnt_nx   = '0;
      done_nx  = 1'b0;
    end else if (last) begin
      state_nx = ST_IDLE;
      done_nx  = 1'b1;
    end else if (state == ST_RUN) begin
      cnt_nx   = cnt + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= ST_IDLE;
      cnt   <= '0;
      done  <= 1'b0;
    end else begin
      state <= state_nx;
      cnt   <= cnt_nx;
      done  <= done_nx;
    end
  end

  assign run      = (state == ST_RUN);
  assign feed_vld = run && (cnt < NLIM);
  assign step     = cnt[IW-1:0];

  // R5: a start during a run neither restarts nor stalls the count
  p_start_ignored_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (run && start && !last) |=> (run && (cnt == $past(cnt) + 1'b1)));
  // R4: done is never high while running
  p_done_when_idle_r4: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !run);
  // R4: done rises only as the final count retires
  p_done_rise_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done) |-> ($past(run) && ($past(cnt) == LAST)));
endmodule

// File: rtl/smm_top.sv
module smm_top #(
  parameter int N  = 8,
  parameter int DW = 8,
  parameter int AW = 19,
  localparam int IW = $clog2(N)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          a_we,
  input  logic [IW-1:0] a_row,
  input  logic [IW-1:0] a_col,
  input  logic [DW-1:0] a_data,
  input  logic          b_we,
  input  logic [IW-1:0] b_row,
  input  logic [IW-1:0] b_col,
  input  logic [DW-1:0] b_data,
  input  logic          start,
  output logic          done,
  input  logic [IW-1:0] rd_row,
  input  logic [IW-1:0] rd_col,
  output logic [AW-1:0] rd_data
);
  logic          fire, run, feed_vld;
  logic [IW-1:0] step;
  logic [DW-1:0] a_feed [N];
  logic [DW-1:0] b_feed [N];
  logic [DW-1:0] a_sk   [N];
  logic [DW-1:0] b_sk   [N];
  logic [DW-1:0] a_link [N][N];
  logic [DW-1:0] b_link [N][N];
  logic [AW-1:0] acc_w  [N][N];
  logic [AW-1:0] rd_nx;

  smm_ctrl #(.N(N)) u_ctrl (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (start),
    .fire     (fire),
    .run      (run),
    .feed_vld (feed_vld),
    .step     (step),
    .done     (done)
  );

  // A: lane = row i, step = column k
  smm_opbuf #(.N(N), .DW(DW)) u_abuf (
    .clk      (clk),
    .wr_en    (a_we),
    .wr_lane  (a_row),
    .wr_step  (a_col),
    .wr_data  (a_data),
    .rd_vld   (feed_vld),
    .rd_step  (step),
    .lane_out (a_feed)
  );

  // B: lane = column j, step = row k
  smm_opbuf #(.N(N), .DW(DW)) u_bbuf (
    .clk      (clk),
    .wr_en    (b_we),
    .wr_lane  (b_col),
    .wr_step  (b_row),
    .wr_data  (b_data),
    .rd_vld   (feed_vld),
    .rd_step  (step),
    .lane_out (b_feed)
  );

  smm_skew #(.N(N), .DW(DW)) u_askew (
    .clk (clk), .rst_n (rst_n), .din (a_feed), .dout (a_sk)
  );

  smm_skew #(.N(N), .DW(DW)) u_bskew (
    .clk (clk), .rst_n (rst_n), .din (b_feed), .dout (b_sk)
  );

  for (genvar i = 0; i < N; i++) begin : g_row
    for (genvar j = 0; j < N; j++) begin : g_col
      logic [DW-1:0] a_w, b_w;
      if (j == 0) begin : g_aw
        assign a_w = a_sk[i];
      end else begin : g_an
        assign a_w = a_link[i][j-1];
      end
      if (i == 0) begin : g_bw
        assign b_w = b_sk[j];
      end else begin : g_bn
        assign b_w = b_link[i-1][j];
      end

      smm_cell #(.DW(DW), .AW(AW)) u_cell (
        .clk   (clk),
        .rst_n (rst_n),
        .en    (run),
        .clr   (fire),
        .a_in  (a_w),
        .b_in  (b_w),
        .a_out (a_link[i][j]),
        .b_out (b_link[i][j]),
        .acc   (acc_w[i][j])
      );
    end
  end

  always_comb begin
    rd_nx = acc_w[rd_row][rd_col];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_data <= '0;
    end else begin
      rd_data <= rd_nx;
    end
  end
endmodule

// File: tb/test_smm_top.sv
`timescale 1ns/1ps
module test_smm_top;
  localparam int N  = 8;
  localparam int DW = 8;
  localparam int AW = 19;
  localparam int IW = $clog2(N);
  localparam int LAT = 3 * N - 2;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          a_we, b_we, start;
  logic [IW-1:0] a_row, a_col, b_row, b_col, rd_row, rd_col;
  logic [DW-1:0] a_data, b_data;
  logic          done;
  logic [AW-1:0] rd_data;

  int total = 0;
  int bad   = 0;
  int sa [N][N];
  int sb [N][N];

  // reference model state
  int  c_ref  [N][N];
  int  c_pend [N][N];
  bit  m_busy, m_done, m_valid, rd_chk;
  int  m_cnt, rd_exp;

  always #2.5 clk = ~clk;

  smm_top #(.N(N), .DW(DW), .AW(AW)) i_smm_top (
    .clk (clk), .rst_n (rst_n),
    .a_we (a_we), .a_row (a_row), .a_col (a_col), .a_data (a_data),
    .b_we (b_we), .b_row (b_row), .b_col (b_col), .b_data (b_data),
    .start (start), .done (done),
    .rd_row (rd_row), .rd_col (rd_col), .rd_data (rd_data)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic int prod_at(input int i, input int j);
    int s = 0;
    for (int k = 0; k < N; k++) s += sa[i][k] * sb[k][j];
    return s;
  endfunction

  // behavioural model, advanced on every rising edge
  always @(posedge clk) begin
    if (!rst_n) begin
      m_busy = 0; m_done = 0; m_valid = 1; m_cnt = 0; rd_chk = 0;
      for (int i = 0; i < N; i++)
        for (int j = 0; j < N; j++) c_ref[i][j] = 0;
    end else begin
      rd_chk = m_valid;
      rd_exp = c_ref[rd_row][rd_col];
      if (start && !m_busy) begin
        m_busy = 1; m_cnt = 0; m_done = 0; m_valid = 0;
        for (int i = 0; i < N; i++)
          for (int j = 0; j < N; j++) c_pend[i][j] = prod_at(i, j);
      end else if (m_busy) begin
        if (m_cnt == LAT - 1) begin
          m_busy = 0; m_done = 1; m_valid = 1;
          c_ref = c_pend;
        end else begin
          m_cnt++;
        end
      end
    end
  end

  // per-cycle comparison against the model
  always @(negedge clk) begin
    if (rst_n) begin
      chk(done == m_done, "R4 done per cycle", int'(done), int'(m_done));
      if (rd_chk) chk(int'(rd_data) == rd_exp, "R6 readout per cycle", int'(rd_data), rd_exp);
    end
  end

  task automatic put_a(input int i, input int k, input int v);
    a_we = 1; a_row = IW'(i); a_col = IW'(k); a_data = DW'(v); sa[i][k] = v;
    @(negedge clk);
    a_we = 0;
  endtask

  task automatic put_b(input int k, input int j, input int v);
    b_we = 1; b_row = IW'(k); b_col = IW'(j); b_data = DW'(v); sb[k][j] = v;
    @(negedge clk);
    b_we = 0;
  endtask

  // mode 0 random, 1 identity, 2 all max
  task automatic load(input int amode, input int bmode);
    for (int i = 0; i < N; i++)
      for (int k = 0; k < N; k++)
        put_a(i, k, amode == 1 ? (i == k ? 1 : 0) : amode == 2 ? 255 : int'($urandom_range(255)));
    for (int k = 0; k < N; k++)
      for (int j = 0; j < N; j++)
        put_b(k, j, bmode == 2 ? 255 : int'($urandom_range(255)));
  endtask

  task automatic run(input bit extra, output int n);
    start = 1;
    @(negedge clk);
    start = 0;
    n = 0;
    while (!done && n < 1000) begin
      start = extra && (n == 3 || n == LAT - 1);
      @(negedge clk);
      n++;
    end
    start = 0;
  endtask

  task automatic read_all(input string tag);
    for (int i = 0; i < N; i++)
      for (int j = 0; j < N; j++) begin
        rd_row = IW'(i); rd_col = IW'(j);
        @(negedge clk);
        chk(int'(rd_data) == prod_at(i, j), tag, int'(rd_data), prod_at(i, j));
      end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int n;
    rst_n = 0; a_we = 0; b_we = 0; start = 0;
    a_row = '0; a_col = '0; b_row = '0; b_col = '0; a_data = '0; b_data = '0;
    rd_row = '0; rd_col = '0;
    repeat (4) @(negedge clk);
    rst_n = 1;
    @(negedge clk);

    // R1 reset state
    chk(done == 1'b0, "R1 done after reset", int'(done), 0);
    rd_row = 3; rd_col = 5;
    @(negedge clk);
    chk(rd_data == '0, "R1 result after reset", int'(rd_data), 0);

    // R2 random product, R4 latency
    load(0, 0);
    run(0, n);
    chk(n == LAT, "R4 start-to-done cycles", n, LAT);
    read_all("R2 R6 random product");
    repeat (3) @(negedge clk);
    chk(done == 1'b1, "R4 done holds", int'(done), 1);

    // R9 identity times B
    load(1, 0);
    run(0, n);
    for (int i = 0; i < N; i++)
      for (int j = 0; j < N; j++) begin
        rd_row = IW'(i); rd_col = IW'(j);
        @(negedge clk);
        chk(int'(rd_data) == sb[i][j], "R9 identity", int'(rd_data), sb[i][j]);
      end

    // R7 rerun without reload; R3 no leftover sums
    run(0, n);
    read_all("R7 R3 rerun stored operands");
    put_a(2, 3, 200);
    put_b(3, 6, 77);
    run(0, n);
    read_all("R3 R7 single element rewrite");

    // R5 start pulses during a run
    load(0, 0);
    run(1, n);
    chk(n == LAT, "R5 cycles with extra start", n, LAT);
    read_all("R5 results with extra start");

    // R8 all operands at maximum
    load(2, 2);
    run(0, n);
    read_all("R8 maximum operands");
    rd_row = IW'(N - 1); rd_col = IW'(N - 1);
    @(negedge clk);
    chk(int'(rd_data) == N * 255 * 255, "R8 corner value", int'(rd_data), N * 255 * 255);

    repeat (2) @(negedge clk);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule